// File: doc/BRIEF.md
# I2C Transmit Arbitration Monitor

This block watches a bus master while it transmits. On every rising edge of SCL in a data bit, it compares the bit the master is driving with the level it reads back from SDA. If the two differ, another master pulled the line low and this master has lost arbitration. The result appears on a single arbitration flag. A mode input selects how the flag behaves. In per-bit mode the flag follows each compared bit. In per-byte mode a loss anywhere in the byte is remembered, and the flag is raised when the acknowledge clock of that byte ends.

An optional release feature turns off the SDA output driver as soon as a mismatch is seen. The driver stays off until software clears it or a new START arrives. SCL and SDA enter the block asynchronously and pass through two-flop synchronizers. A small state machine tracks where the bus is within a byte. Its states are:

- `ST_IDLE`: no transfer is in progress.
- `ST_ARMED`: a START has been seen and the first SCL fall has not yet occurred.
- `ST_DATA`: data bits 1 to 8.
- `ST_ACK`: the 9th bit, the acknowledge.

Its transitions are:

- START, from any state, goes to `ST_ARMED`.
- STOP, from any state, goes to `ST_IDLE`.
- An SCL fall in `ST_ARMED` goes to `ST_DATA`.
- The SCL fall that ends the 8th bit goes from `ST_DATA` to `ST_ACK`.
- The 9th SCL fall goes from `ST_ACK` back to `ST_DATA` and latches the per-byte result.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, `arb_lost` and `sda_off` are both 0, and the state is idle.
- R2: A comparison takes place only on an SCL rising edge during data bits 1 to 8 of a byte, and only while `tx_drive` is 1. The 9th (acknowledge) bit and any bit with `tx_drive` = 0 are never compared.
- R3: With `byte_mode` = 0, each compared edge sets `arb_lost` to 1 when `tx_bit` differs from SDA and to 0 when they match. The flag changes 3 clock cycles after the raw SCL input rises.
- R4: With `byte_mode` = 1, a mismatch on any compared bit is remembered. `arb_lost` rises at the 9th SCL falling edge of that byte and does not change before it.
- R5: In per-byte mode the remembered mismatch is cleared at the 9th falling edge. The next byte therefore starts clean, and hardware never lowers `arb_lost` itself.
- R6: A one-cycle `sw_clear` pulse lowers both `arb_lost` and `sda_off`. If a set event falls in the same cycle, the set wins.
- R7: With `rel_en` = 1, a compared mismatch raises `sda_off` on the same cycle as that edge's comparison. With `rel_en` = 0, `sda_off` never rises.
- R8: Once raised, `sda_off` stays 1 until `sw_clear` or a START condition, even if later bits match.
- R9: A START (SDA falls while SCL is high) restarts the bit count, and the first SCL fall after it opens bit 1. A STOP (SDA rises while SCL is high) returns the block to idle, and no comparisons are made while idle.
- R10: `scl_in` and `sda_in` each pass through two synchronizer flops before any edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| tx_bit | input | 1 | Bit the transmitter is currently driving |
| tx_drive | input | 1 | 1 while this master drives the data bit |
| byte_mode | input | 1 | 0 = per-bit flag update, 1 = per-byte sticky flag |
| rel_en | input | 1 | 1 = release SDA when a mismatch is seen |
| sw_clear | input | 1 | Software clear pulse for the flag and the release |
| arb_lost | output | 1 | Arbitration lost flag |
| sda_off | output | 1 | SDA output-disable (1 = high impedance) |

## Verification
Any change on the raw SCL pin reaches the registered results three clock edges later: two synchronizer stages, then the flag register. A per-bit result is therefore due three cycles after SCL rises, and a per-byte result three cycles after the 9th SCL fall. The bench holds every SCL phase for six cycles and samples at the end of each phase, on the falling clock edge. This leaves a margin on either side of the update. One directed test instead samples two and three cycles after the raw rise, pinning the exact cycle on which the flag changes.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DATA  = 2'd2,
        ST_ACK   = 2'd3
    } arb_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    localparam int unsigned LINE_SCL = 0;
    localparam int unsigned LINE_SDA = 1;
    localparam int unsigned LINE_CNT = 2;

endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= {WIDTH{RST_VAL}};
        else        pipe[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= {WIDTH{RST_VAL}};
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_arb_cond.sv
module i2c_arb_cond
    import i2c_arb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output line_ev_t ev
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_arb_cnt.sv
module i2c_arb_cnt #(
    parameter int unsigned BITS = 8,
    localparam int unsigned LAST = BITS + 1,
    localparam int unsigned W    = $clog2(LAST + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         at_data_end,
    output logic         at_ack
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (step)  cnt <= (cnt == W'(LAST)) ? W'(1) : cnt + W'(1);
    end

    assign at_data_end = (cnt == W'(BITS));
    assign at_ack      = (cnt == W'(LAST));
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
    import i2c_arb_pkg::*;
#(
    parameter int unsigned BITS       = 8,
    parameter int unsigned SYNC_DEPTH = 2,
    localparam int unsigned CW = $clog2(BITS + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic tx_bit,
    input  logic tx_drive,
    input  logic byte_mode,
    input  logic rel_en,
    input  logic sw_clear,
    output logic arb_lost,
    output logic sda_off
);
    logic [LINE_CNT-1:0] raw_lines;
    logic [LINE_CNT-1:0] sync_lines;
    line_ev_t            ev;
    arb_state_t          state, state_n;
    logic [CW-1:0]       bit_cnt;
    logic                at_data_end, at_ack;
    logic                cnt_step;
    logic                compare_en, mismatch, byte_latch;
    logic                sticky, sticky_n, flag_n, off_n;
    logic                scl_rise, scl_fall, start_det;

    assign raw_lines[LINE_SCL] = scl_in;
    assign raw_lines[LINE_SDA] = sda_in;

    i2c_arb_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
    );

    i2c_arb_cond u_cond (
        .clk(clk), .rst_n(rst_n),
        .scl_s(sync_lines[LINE_SCL]), .sda_s(sync_lines[LINE_SDA]), .ev(ev)
    );

    assign scl_rise  = ev.scl_rise;
    assign scl_fall  = ev.scl_fall;
    assign start_det = ev.start;
    assign cnt_step  = ev.scl_fall && (state != ST_IDLE);

    i2c_arb_cnt #(.BITS(BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ev.start), .step(cnt_step),
        .cnt(bit_cnt), .at_data_end(at_data_end), .at_ack(at_ack)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (ev.start) begin
            state_n = ST_ARMED;
        end else if (ev.stop) begin
            state_n = ST_IDLE;
        end else if (ev.scl_fall) begin
            unique case (state)
                ST_IDLE:  state_n = ST_IDLE;
                ST_ARMED: state_n = ST_DATA;
                ST_DATA:  state_n = at_data_end ? ST_ACK : ST_DATA;
                ST_ACK:   state_n = ST_DATA;
            endcase
        end
    end

    // Comparison qualifiers
    assign compare_en = (state == ST_DATA) && tx_drive && ev.scl_rise;
    assign mismatch   = compare_en && (tx_bit != sync_lines[LINE_SDA]);
    assign byte_latch = (state == ST_ACK) && ev.scl_fall;

    // Output next values: set events take priority over software clear
    always_comb begin
        flag_n   = arb_lost;
        off_n    = sda_off;
        sticky_n = sticky;
        if (sw_clear) begin
            flag_n = 1'b0;
            off_n  = 1'b0;
        end
        if (ev.start) begin
            off_n    = 1'b0;
            sticky_n = 1'b0;
        end
        if (byte_mode) begin
            if (mismatch) sticky_n = 1'b1;
            if (byte_latch) begin
                sticky_n = 1'b0;
                if (sticky) flag_n = 1'b1;
            end
        end else if (compare_en) begin
            flag_n = mismatch;
        end
        if (rel_en && mismatch) off_n = 1'b1;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_lost <= 1'b0;
            sda_off  <= 1'b0;
            sticky   <= 1'b0;
        end else begin
            arb_lost <= flag_n;
            sda_off  <= off_n;
            sticky   <= sticky_n;
        end
    end
endmodule

// File: rtl/i2c_arb_monitor_chk.sv
module i2c_arb_monitor_chk
    import i2c_arb_pkg::*;
#(
    parameter int unsigned BITS = 8,
    localparam int unsigned CW = $clog2(BITS + 2)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_mode,
    input logic          rel_en,
    input logic          sw_clear,
    input logic          arb_lost,
    input logic          sda_off,
    input logic          scl_rise,
    input logic          scl_fall,
    input logic          start_det,
    input arb_state_t    state,
    input logic [CW-1:0] bit_cnt
);
    assert_bit_flag_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arb_lost) && !$past(byte_mode)) |-> $past(scl_rise));

    assert_byte_flag_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(arb_lost) && $past(byte_mode)) |-> ($past(scl_fall) && $past(state) == ST_ACK));

    assert_clear_wins_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && !scl_rise && !scl_fall) |=> (!arb_lost && !sda_off));

    assert_release_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_off) |-> ($past(rel_en) && $past(scl_rise)));

    assert_release_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_off && !sw_clear && !start_det) |=> sda_off);

    assert_ack_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> (bit_cnt == CW'(BITS + 1)));

    assert_armed_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> (bit_cnt == '0));
endmodule

bind i2c_arb_monitor i2c_arb_monitor_chk #(.BITS(BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .rel_en(rel_en),
    .sw_clear(sw_clear), .arb_lost(arb_lost), .sda_off(sda_off),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .state(state), .bit_cnt(bit_cnt)
);

// File: tb/i2c_arb_monitor_bench.sv
`timescale 1ns/1ps
module i2c_arb_monitor_bench;
    localparam int HALF  = 6;
    localparam int NVEC  = 8;
    // vector: {byte_mode, rel_en, tx_byte[7:0], bus_byte[7:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'hA5, 8'hA5},
        {1'b0, 1'b0, 8'hA5, 8'hA4},
        {1'b0, 1'b1, 8'hFF, 8'h7F},
        {1'b1, 1'b0, 8'h3C, 8'h3C},
        {1'b1, 1'b0, 8'hF0, 8'h70},
        {1'b1, 1'b1, 8'h81, 8'h01},
        {1'b0, 1'b1, 8'h55, 8'h55},
        {1'b1, 1'b1, 8'hC3, 8'hC3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1, sda_r = 1'b1;
    logic tx_bit = 1'b1, tx_drive = 1'b0;
    logic byte_mode = 1'b0, rel_en = 1'b0, sw_clear = 1'b0;
    logic arb_lost, sda_off;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_arb_monitor u_i2c_arb_monitor (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_r), .sda_in(sda_r),
        .tx_bit(tx_bit), .tx_drive(tx_drive), .byte_mode(byte_mode),
        .rel_en(rel_en), .sw_clear(sw_clear), .arb_lost(arb_lost), .sda_off(sda_off)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_start();
        sda_r = 1'b1; scl_r = 1'b1; wait_half();
        sda_r = 1'b0; wait_half();
        scl_r = 1'b0; wait_half();
    endtask

    task automatic do_stop();
        sda_r = 1'b0; wait_half();
        scl_r = 1'b1; wait_half();
        sda_r = 1'b1; wait_half();
    endtask

    task automatic bit_hi(input logic tb, input logic sb, input logic act);
        tx_bit = tb; tx_drive = act; sda_r = sb; wait_half();
        scl_r = 1'b1; wait_half();
    endtask

    task automatic bit_lo();
        scl_r = 1'b0; wait_half();
    endtask

    task automatic send_byte(input logic [7:0] tx, input logic [7:0] bus, input logic act);
        for (int i = 7; i >= 0; i--) begin
            bit_hi(tx[i], bus[i], act);
            bit_lo();
        end
        bit_hi(1'b1, 1'b0, 1'b0);
        bit_lo();
    endtask

    task automatic pulse_clear();
        sw_clear = 1'b1; @(negedge clk);
        sw_clear = 1'b0; repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 flag", arb_lost, 1'b0);
        check("R1 release", sda_off, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: one byte per entry, expected values from R3/R4/R7
        for (int v = 0; v < NVEC; v++) begin
            logic [17:0] e;
            logic ef, er;
            e = VEC[v];
            byte_mode = e[17]; rel_en = e[16];
            pulse_clear();
            do_start();
            send_byte(e[15:8], e[7:0], 1'b1);
            ef = e[17] ? (e[15:8] != e[7:0]) : (e[8] != e[0]);
            er = e[16] && (e[15:8] != e[7:0]);
            check(e[17] ? "R4 vector flag" : "R3 vector flag", arb_lost, ef);
            check("R7 vector release", sda_off, er);
            do_stop();
        end

        // R3 / R10: exact latency of three edges after raw SCL rise
        byte_mode = 1'b0; rel_en = 1'b0;
        pulse_clear();
        do_start();
        tx_bit = 1'b1; tx_drive = 1'b1; sda_r = 1'b0; wait_half();
        scl_r = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 not before sync", arb_lost, 1'b0);
        @(negedge clk);
        check("R3 three-cycle latency", arb_lost, 1'b1);
        wait_half(); bit_lo();
        bit_hi(1'b0, 1'b0, 1'b1);
        check("R3 cleared on match", arb_lost, 1'b0);
        bit_lo();
        for (int i = 0; i < 6; i++) begin bit_hi(1'b1, 1'b1, 1'b1); bit_lo(); end
        // R2: ack bit not compared even with tx_drive high
        bit_hi(1'b1, 1'b0, 1'b1);
        check("R2 ack ignored", arb_lost, 1'b0);
        bit_lo();
        // R2: inactive data bits not compared
        send_byte(8'hFF, 8'h00, 1'b0);
        check("R2 tx_drive low ignored", arb_lost, 1'b0);
        do_stop();

        // R9: no compares while idle
        bit_hi(1'b1, 1'b0, 1'b1);
        check("R9 idle no compare", arb_lost, 1'b0);
        bit_lo();
        sda_r = 1'b1; wait_half();
        scl_r = 1'b1; wait_half();

        // R4 / R5: sticky per-byte mode
        byte_mode = 1'b1;
        do_start();
        for (int i = 0; i < 8; i++) begin
            bit_hi(1'b1, (i == 1) ? 1'b0 : 1'b1, 1'b1);
            if (i == 7) check("R4 no early flag", arb_lost, 1'b0);
            bit_lo();
        end
        bit_hi(1'b1, 1'b0, 1'b0);
        check("R4 before 9th fall", arb_lost, 1'b0);
        bit_lo();
        check("R4 latched at 9th fall", arb_lost, 1'b1);
        send_byte(8'h5A, 8'h5A, 1'b1);
        check("R5 flag kept by hw", arb_lost, 1'b1);
        pulse_clear();
        check("R6 clear flag", arb_lost, 1'b0);
        send_byte(8'h5A, 8'h5A, 1'b1);
        check("R5 memory cleared", arb_lost, 1'b0);
        do_stop();

        // R7 / R8: release hold
        byte_mode = 1'b0; rel_en = 1'b1;
        do_start();
        bit_hi(1'b1, 1'b0, 1'b1);
        check("R7 release raised", sda_off, 1'b1);
        bit_lo();
        bit_hi(1'b0, 1'b0, 1'b1);
        check("R3 match lowers flag", arb_lost, 1'b0);
        check("R8 release held", sda_off, 1'b1);
        bit_lo();
        pulse_clear();
        check("R6 clear release", sda_off, 1'b0);
        bit_hi(1'b1, 1'b0, 1'b1);
        check("R7 release again", sda_off, 1'b1);
        bit_lo();
        do_stop();
        check("R8 held across stop", sda_off, 1'b1);
        do_start();
        check("R8 start releases", sda_off, 1'b0);
        rel_en = 1'b0;
        bit_hi(1'b1, 1'b0, 1'b1);
        check("R7 disabled no release", sda_off, 1'b0);
        check("R3 flag without release", arb_lost, 1'b1);
        bit_lo();
        do_stop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule